// File: doc/BRIEF.md
# Sector Buffer Storage Controller

This block sits between a processor and main storage and keeps a small, fast copy of recently fetched storage. The copy is organized in 16 sectors of 1,024 bytes. Each sector is tied to one aligned 1,024-byte region of main storage by a tag. Data inside a sector is brought in on demand, one 64-byte block at a time, and each block has its own presence bit. A processor fetch that hits a present block is answered from the local array. A fetch that misses loads the addressed block. The quadword that holds the requested data is fetched first and returned at once. The other three quadwords of the block follow one at a time.

All stores, whether from the processor or an I/O channel, are written through to main storage. The local copy is updated only when the addressed block is already present. Stores never claim a sector and never start a load. Channel fetches go straight to main storage. Sector replacement follows a strict recency order, and only processor fetches change that order. The requester gives one request at a time on a valid/ready port, with a 24-bit byte address and a 128-bit quadword. The main-storage side moves one quadword per transfer. Its responses return in order.

Top module: `sectorBufferCtl`

## Requirements
- R1: After reset `reqReady` is 1, `rspValid` is 0 and `memReq` is 0, and every sector is unassigned, so the first processor fetch causes memory reads.
- R2: A processor fetch that misses issues exactly 4 memory reads (`memWrite`=0), all inside the addressed 64-byte block (address bits 23:6 equal to the request's). A different block of an already assigned sector is loaded by its own 4 reads.
- R3: A block load reads quadwords in the order q, q+1, q+2, q+3 modulo 4, where q is request address bits 5:4. The response carries the first returned quadword. `rspValid` is raised before the second read of the block is accepted.
- R4: A processor fetch to a present block makes no memory transfer. `rspValid` is high for exactly one cycle, starting at the clock edge right after the accepting edge, and carries the stored quadword.
- R5: Every processor fetch makes its sector the most recent. When all sectors are assigned, a fetch miss replaces the least recently fetched sector.
- R6: While any sector is unassigned, a miss uses an unassigned sector (lowest index first) and evicts nothing.
- R7: Each store (`reqWrite`=1, from processor or channel) causes exactly one memory write with the quadword-aligned request address and the request data. If the block is present, a later processor fetch returns the stored data with no memory read.
- R8: A store never assigns a sector, never loads a block and never changes the recency order.
- R9: A channel fetch (`reqWrite`=0, `reqChan`=1) always makes exactly one memory read and returns that data, even when the sector is present, and does not change the recency order.
- R10: Once a request is accepted, `reqReady` stays 0 until all memory transfers for it (including the rest of a block load) are done.
- R11: While `memReq` is 1 and `memAck` is 0, `memReq`, `memWrite` and `memAddr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request taken on this edge |
| reqWrite | input | 1 | 1 = store, 0 = fetch |
| reqChan | input | 1 | 1 = channel request, 0 = processor request |
| reqAddr | input | 24 | Byte address |
| reqWData | input | 128 | Store quadword |
| rspValid | output | 1 | One-cycle fetch response strobe |
| rspData | output | 128 | Fetched quadword |
| memReq | output | 1 | Main-storage transfer request |
| memAck | input | 1 | Main storage takes the request on this edge |
| memWrite | output | 1 | 1 = write transfer |
| memAddr | output | 24 | Quadword-aligned byte address |
| memWData | output | 128 | Write quadword |
| memRValid | input | 1 | Read data returned (in request order) |
| memRData | input | 128 | Read quadword |

## Verification
A corrupted tag, presence bit or recency entry does not show up right away as wrong data. It shows up in the count of memory reads on a later fetch. A block that should hit costs four extra reads, and a wrong victim turns a later fetch of a sector that should be resident into a miss. The bench therefore counts memory reads and writes around every request, and it checks the order of the load addresses. It replays a planned sequence of fetches and stores, so each recency mistake is caught one or two requests after it happens. Data errors in the array show up on the very next hit response.

// File: rtl/sbcPkg.sv
package sbcPkg;
  localparam int ADDR_W      = 24;
  localparam int DATA_W      = 128;
  localparam int SECTOR_LOG  = 10;
  localparam int BLOCK_LOG   = 6;
  localparam int QW_LOG      = 4;
  localparam int NUM_SECTORS = 16;

  localparam int SEC_W  = $clog2(NUM_SECTORS);
  localparam int BLK_W  = SECTOR_LOG - BLOCK_LOG;
  localparam int QWS_W  = BLOCK_LOG - QW_LOG;
  localparam int TAG_W  = ADDR_W - SECTOR_LOG;
  localparam int BLOCKS = 1 << BLK_W;
  localparam int QWS    = 1 << QWS_W;
  localparam int ARR_W  = SEC_W + BLK_W + QWS_W;
  localparam int ARR_DEPTH = 1 << ARR_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_WRITE, ST_CHRD, ST_CHWAIT, ST_LDREQ, ST_LDWAIT
  } sbcState_t;

  typedef struct packed {
    logic             reqLatch;
    logic             arrWe;
    logic             arrFromMem;
    logic [SEC_W-1:0] arrSector;
    logic [BLK_W-1:0] arrBlock;
    logic [QWS_W-1:0] arrQw;
    logic             rspLoad;
    logic             rspFromMem;
  } sbcStrobe_t;
endpackage

// File: rtl/sbcRecency.sv
module sbcRecency
  import sbcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             touch,
  input  logic [SEC_W-1:0] touchSector,
  output logic [SEC_W-1:0] lruBottom
);
  // order[0] is most recent, order[NUM_SECTORS-1] least recent
  logic [SEC_W-1:0] order [NUM_SECTORS];
  logic [SEC_W-1:0] pos;

  always_comb begin
    pos = SEC_W'(NUM_SECTORS - 1);
    for (int i = 0; i < NUM_SECTORS; i++) begin
      if (order[i] == touchSector) pos = SEC_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SECTORS; i++) order[i] <= SEC_W'(i);
    end else if (touch) begin
      order[0] <= touchSector;
      for (int i = 1; i < NUM_SECTORS; i++) begin
        if (SEC_W'(i) <= pos) order[i] <= order[i-1];
      end
    end
  end

  assign lruBottom = order[NUM_SECTORS-1];
endmodule

// File: rtl/sbcControl.sv
module sbcControl
  import sbcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqChan,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              memAck,
  input  logic              memRValid,
  input  logic [SEC_W-1:0]  lruBottom,
  output logic              reqReady,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output sbcStrobe_t        strobe,
  output logic              touch,
  output logic [SEC_W-1:0]  touchSector
);
  sbcState_t state, stateNext;

  logic             isWrite, isChan;
  logic [TAG_W-1:0] tagQ;
  logic [BLK_W-1:0] blkQ;
  logic [QWS_W-1:0] qwQ, ldCnt, fillQw;
  logic [SEC_W-1:0] curSector;

  logic [TAG_W-1:0]       tags [NUM_SECTORS];
  logic [NUM_SECTORS-1:0] assigned;
  logic [BLOCKS-1:0]      blkValid [NUM_SECTORS];

  logic [NUM_SECTORS-1:0] hitVec;
  logic [SEC_W-1:0]       hitSector, freeSector, victim;
  logic                   hit, freeAny, hitValid, lastQ;

  genvar g;
  generate
    for (g = 0; g < NUM_SECTORS; g++) begin : gTagCmp
      assign hitVec[g] = assigned[g] && (tags[g] == tagQ);
    end
  endgenerate

  always_comb begin
    hitSector  = '0;
    freeSector = '0;
    for (int i = NUM_SECTORS - 1; i >= 0; i--) begin
      if (hitVec[i])    hitSector  = SEC_W'(i);
      if (!assigned[i]) freeSector = SEC_W'(i);
    end
  end

  assign hit      = |hitVec;
  assign freeAny  = ~&assigned;
  assign victim   = freeAny ? freeSector : lruBottom;
  assign hitValid = hit && blkValid[hitSector][blkQ];
  assign fillQw   = qwQ + ldCnt;
  assign lastQ    = (ldCnt == QWS_W'(QWS - 1));

  always_comb begin
    stateNext   = state;
    reqReady    = 1'b0;
    memReq      = 1'b0;
    memWrite    = 1'b0;
    memAddr     = {tagQ, blkQ, qwQ, {QW_LOG{1'b0}}};
    touch       = 1'b0;
    touchSector = hit ? hitSector : victim;
    strobe      = '0;
    strobe.arrSector = hitSector;
    strobe.arrBlock  = blkQ;
    strobe.arrQw     = qwQ;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.reqLatch = 1'b1;
          stateNext = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (isWrite) begin
          strobe.arrWe = hitValid;
          stateNext = ST_WRITE;
        end else if (isChan) begin
          stateNext = ST_CHRD;
        end else if (hitValid) begin
          strobe.rspLoad = 1'b1;
          touch = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          touch = 1'b1;
          stateNext = ST_LDREQ;
        end
      end
      ST_WRITE: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memAck) stateNext = ST_IDLE;
      end
      ST_CHRD: begin
        memReq = 1'b1;
        if (memAck) stateNext = ST_CHWAIT;
      end
      ST_CHWAIT: begin
        if (memRValid) begin
          strobe.rspLoad    = 1'b1;
          strobe.rspFromMem = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_LDREQ: begin
        memReq  = 1'b1;
        memAddr = {tagQ, blkQ, fillQw, {QW_LOG{1'b0}}};
        if (memAck) stateNext = ST_LDWAIT;
      end
      ST_LDWAIT: begin
        strobe.arrSector = curSector;
        strobe.arrQw     = fillQw;
        if (memRValid) begin
          strobe.arrWe      = 1'b1;
          strobe.arrFromMem = 1'b1;
          if (ldCnt == '0) begin
            strobe.rspLoad    = 1'b1;
            strobe.rspFromMem = 1'b1;
          end
          stateNext = lastQ ? ST_IDLE : ST_LDREQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      isWrite   <= 1'b0;
      isChan    <= 1'b0;
      tagQ      <= '0;
      blkQ      <= '0;
      qwQ       <= '0;
      ldCnt     <= '0;
      curSector <= '0;
      assigned  <= '0;
      for (int i = 0; i < NUM_SECTORS; i++) begin
        tags[i]     <= '0;
        blkValid[i] <= '0;
      end
    end else begin
      state <= stateNext;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          isWrite <= reqWrite;
          isChan  <= reqChan;
          tagQ    <= reqAddr[ADDR_W-1:SECTOR_LOG];
          blkQ    <= reqAddr[SECTOR_LOG-1:BLOCK_LOG];
          qwQ     <= reqAddr[BLOCK_LOG-1:QW_LOG];
        end
        ST_DECIDE: if (!isWrite && !isChan && !hitValid) begin
          ldCnt <= '0;
          if (hit) begin
            curSector <= hitSector;
          end else begin
            curSector        <= victim;
            tags[victim]     <= tagQ;
            assigned[victim] <= 1'b1;
            blkValid[victim] <= '0;
          end
        end
        ST_LDWAIT: if (memRValid) begin
          if (lastQ) blkValid[curSector][blkQ] <= 1'b1;
          else       ldCnt <= ldCnt + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbcDataPath.sv
module sbcDataPath
  import sbcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sbcStrobe_t        strobe,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [DATA_W-1:0] memRData,
  output logic [DATA_W-1:0] memWData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic [DATA_W-1:0] arr [ARR_DEPTH];
  logic [DATA_W-1:0] wdataQ;
  logic [ARR_W-1:0]  arrIdx;

  assign arrIdx   = {strobe.arrSector, strobe.arrBlock, strobe.arrQw};
  assign memWData = wdataQ;

  always_ff @(posedge clk) begin
    if (strobe.arrWe) arr[arrIdx] <= strobe.arrFromMem ? memRData : wdataQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdataQ   <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.reqLatch) wdataQ <= reqWData;
      rspValid <= strobe.rspLoad;
      if (strobe.rspLoad) rspData <= strobe.rspFromMem ? memRData : arr[arrIdx];
    end
  end
endmodule

// File: rtl/sectorBufferCtl.sv
module sectorBufferCtl
  import sbcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqChan,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memReq,
  input  logic              memAck,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memRValid,
  input  logic [DATA_W-1:0] memRData
);
  sbcStrobe_t       strobe;
  logic             touch;
  logic [SEC_W-1:0] touchSector, lruBottom;

  sbcControl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqChan(reqChan), .reqAddr(reqAddr), .memAck(memAck),
    .memRValid(memRValid), .lruBottom(lruBottom), .reqReady(reqReady),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .strobe(strobe), .touch(touch), .touchSector(touchSector)
  );

  sbcRecency uLru (
    .clk(clk), .rstN(rstN), .touch(touch), .touchSector(touchSector),
    .lruBottom(lruBottom)
  );

  sbcDataPath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWData(reqWData),
    .memRData(memRData), .memWData(memWData), .rspValid(rspValid),
    .rspData(rspData)
  );
endmodule

// File: rtl/sbcChecker.sv
module sbcChecker
  import sbcPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memReq,
  input logic              memAck,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr
);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWrite));

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R10
  no_accept_in_transfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);

  // R4
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

bind sectorBufferCtl sbcChecker uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .memReq(memReq), .memAck(memAck),
  .memWrite(memWrite), .memAddr(memAddr)
);

// File: tb/sectorBufferCtl_test.sv
module sectorBufferCtl_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0, reqWrite = 1'b0, reqChan = 1'b0;
  logic [23:0]  reqAddr = '0;
  logic [127:0] reqWData = '0;
  logic         reqReady, rspValid, memReq, memWrite;
  logic [127:0] rspData, memWData;
  logic [23:0]  memAddr;
  logic         memAck = 1'b0, memRValid = 1'b0;
  logic [127:0] memRData = '0;

  int tests = 0, fails = 0;

  sectorBufferCtl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqChan(reqChan), .reqAddr(reqAddr),
    .reqWData(reqWData), .rspValid(rspValid), .rspData(rspData),
    .memReq(memReq), .memAck(memAck), .memWrite(memWrite),
    .memAddr(memAddr), .memWData(memWData), .memRValid(memRValid),
    .memRData(memRData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- main storage model and response capture ------------
  logic [127:0] mm [logic [23:0]];
  int           readCnt = 0, writeCnt = 0, ackDelay = 0;
  int           waitCnt = 0, pendCnt = 0;
  logic [127:0] pendData;
  logic [23:0]  readLog [0:255];
  logic [23:0]  lastWAddr;
  logic [127:0] lastWData;
  bit           rspSeen = 0;
  logic [127:0] rspCap;
  int           readsAtRsp = 0;

  function automatic logic [127:0] memVal(input logic [23:0] a);
    if (mm.exists(a)) return mm[a];
    return {8'hA5, a, 8'h5A, ~a, a, 8'h3C, 32'hDEADBEEF ^ {8'h00, a}};
  endfunction

  function automatic logic [23:0] qa(input int tag, input int blk, input int qw);
    return {tag[13:0], blk[3:0], qw[1:0], 4'h0};
  endfunction

  always @(negedge clk) begin
    if (rspValid) begin
      rspSeen    = 1;
      rspCap     = rspData;
      readsAtRsp = readCnt;
    end
    memAck    = 1'b0;
    memRValid = 1'b0;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        memRValid = 1'b1;
        memRData  = pendData;
      end
    end else if (memReq) begin
      if (waitCnt < ackDelay) waitCnt++;
      else begin
        waitCnt = 0;
        memAck  = 1'b1;
        if (memWrite) begin
          mm[memAddr] = memWData;
          lastWAddr   = memAddr;
          lastWData   = memWData;
          writeCnt++;
        end else begin
          readLog[readCnt % 256] = memAddr;
          readCnt++;
          pendData = memVal(memAddr);
          pendCnt  = 2;
        end
      end
    end
  end

  // ---------------- helpers ----------------------------------------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 500; n++) begin
      @(negedge clk); #1;
      if (reqReady && !memReq) break;
    end
  endtask

  task automatic doFetch(input logic [23:0] a, input bit chan,
                         output logic [127:0] data, output int reads,
                         output int lat, output int firstReads, output bit readyAtRsp);
    int r0;
    waitIdle();
    r0 = readCnt; rspSeen = 0;
    reqValid = 1; reqWrite = 0; reqChan = chan; reqAddr = a;
    @(negedge clk); #1;
    reqValid = 0;
    lat = 1;
    while (!rspSeen && lat < 300) begin
      @(negedge clk); #1;
      lat++;
    end
    readyAtRsp = reqReady;
    data = rspCap;
    firstReads = readsAtRsp - r0;
    waitIdle();
    reads = readCnt - r0;
  endtask

  task automatic doStore(input logic [23:0] a, input bit chan, input logic [127:0] d,
                         output int reads, output int writes);
    int r0, w0;
    waitIdle();
    r0 = readCnt; w0 = writeCnt;
    reqValid = 1; reqWrite = 1; reqChan = chan; reqAddr = a; reqWData = d;
    @(negedge clk); #1;
    reqValid = 0; reqWrite = 0;
    waitIdle();
    reads = readCnt - r0; writes = writeCnt - w0;
  endtask

  // fetch and compare data and read count
  task automatic fetchExpect(input string req, input logic [23:0] a, input bit chan,
                             input int expReads, input logic [127:0] expData);
    logic [127:0] d; int rd, lat, fr; bit rdy;
    doFetch(a, chan, d, rd, lat, fr, rdy);
    chk(rd == expReads, req, "memory reads", rd, expReads);
    chk(d == expData, req, "response data", d, expData);
  endtask

  // ---------------- scenarios --------------------------------------------
  task automatic tReset();
    chk(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    chk(rspValid == 1'b0, "R1", "rspValid after reset", rspValid, 0);
    chk(memReq == 1'b0, "R1", "memReq after reset", memReq, 0);
  endtask

  task automatic tMissThenHit();
    logic [127:0] d; int rd, lat, fr; bit rdy;
    int base;
    doFetch(qa(256, 5, 2), 0, d, rd, lat, fr, rdy);
    base = readCnt - 4;
    chk(rd == 4, "R1", "first fetch misses", rd, 4);
    chk(rd == 4, "R2", "reads for one block", rd, 4);
    for (int k = 0; k < 4; k++) begin
      logic [23:0] ea;
      ea = qa(256, 5, (2 + k) % 4);
      chk(readLog[(base + k) % 256] == ea, "R3", "load address order",
          readLog[(base + k) % 256], ea);
      chk(readLog[(base + k) % 256][23:6] == ea[23:6], "R2", "read inside block",
          readLog[(base + k) % 256], ea);
    end
    chk(d == memVal(qa(256, 5, 2)), "R3", "critical quadword data", d, memVal(qa(256, 5, 2)));
    chk(fr == 1, "R3", "response before second read", fr, 1);
    chk(rdy == 1'b0, "R10", "reqReady low while block still loading", rdy, 0);
    doFetch(qa(256, 5, 0), 0, d, rd, lat, fr, rdy);
    chk(rd == 0, "R4", "hit makes no read", rd, 0);
    chk(lat == 2, "R4", "hit response timing", lat, 2);
    chk(d == memVal(qa(256, 5, 0)), "R4", "hit data", d, memVal(qa(256, 5, 0)));
    fetchExpect("R2", qa(256, 7, 0), 0, 4, memVal(qa(256, 7, 0)));
  endtask

  task automatic tFill();
    for (int t = 1; t < 16; t++)
      fetchExpect("R6", qa(256 + t, 0, 0), 0, 4, memVal(qa(256 + t, 0, 0)));
    fetchExpect("R6", qa(256, 5, 1), 0, 0, memVal(qa(256, 5, 1)));
    for (int t = 1; t < 16; t++)
      fetchExpect("R6", qa(256 + t, 0, 1), 0, 0, memVal(qa(256 + t, 0, 1)));
  endtask

  task automatic tRecency();
    // order, least recent first: T0,T1..T15
    fetchExpect("R5", qa(256, 5, 0), 0, 0, memVal(qa(256, 5, 0)));   // T1 now bottom
    fetchExpect("R5", qa(272, 0, 0), 0, 4, memVal(qa(272, 0, 0)));   // T16 evicts T1
    fetchExpect("R5", qa(256, 5, 2), 0, 0, memVal(qa(256, 5, 2)));   // T0 kept
    fetchExpect("R5", qa(257, 0, 0), 0, 4, memVal(qa(257, 0, 0)));   // T1 gone, evicts T2
  endtask

  task automatic tStoreNoReorder();
    int rd, wr;
    doStore(qa(259, 0, 0), 0, 128'h1111, rd, wr);                     // T3 is bottom
    chk(rd == 0, "R8", "store hit makes no read", rd, 0);
    chk(wr == 1, "R7", "store hit writes through", wr, 1);
    fetchExpect("R8", qa(273, 0, 0), 0, 4, memVal(qa(273, 0, 0)));   // T17 evicts T3
    fetchExpect("R8", qa(259, 0, 0), 0, 4, 128'h1111);                // T3 missed
  endtask

  task automatic tChannelFetch();
    // bottom now T5
    fetchExpect("R9", qa(261, 0, 0), 1, 1, memVal(qa(261, 0, 0)));
    fetchExpect("R9", qa(274, 0, 0), 0, 4, memVal(qa(274, 0, 0)));   // evicts T5
    fetchExpect("R9", qa(261, 0, 2), 0, 4, memVal(qa(261, 0, 2)));
  endtask

  task automatic tStoreThrough();
    int rd, wr;
    doStore(qa(256, 5, 1), 0, 128'hCAFE_0001, rd, wr);
    chk(wr == 1, "R7", "processor store write count", wr, 1);
    chk(lastWAddr == qa(256, 5, 1), "R7", "store address", lastWAddr, qa(256, 5, 1));
    chk(lastWData == 128'hCAFE_0001, "R7", "store data", lastWData, 128'hCAFE_0001);
    fetchExpect("R7", qa(256, 5, 1), 0, 0, 128'hCAFE_0001);
    doStore(qa(256, 5, 3), 1, 128'hBEEF_0002, rd, wr);
    chk(wr == 1 && rd == 0, "R7", "channel store one write", wr, 1);
    fetchExpect("R7", qa(256, 5, 3), 0, 0, 128'hBEEF_0002);
  endtask

  task automatic tStoreNoAlloc();
    int rd, wr;
    doStore(qa(300, 0, 0), 0, 128'h0D0D, rd, wr);
    chk(rd == 0, "R8", "store miss loads nothing", rd, 0);
    chk(wr == 1, "R7", "store miss writes through", wr, 1);
    fetchExpect("R8", qa(300, 0, 0), 0, 4, 128'h0D0D);
  endtask

  task automatic tHeld();
    int rd, wr;
    ackDelay = 2;
    doStore(qa(256, 5, 0), 0, 128'h4444, rd, wr);
    chk(wr == 1 && lastWAddr == qa(256, 5, 0), "R11", "slow store address",
        lastWAddr, qa(256, 5, 0));
    fetchExpect("R11", qa(301, 3, 1), 0, 4, memVal(qa(301, 3, 1)));
    ackDelay = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    tReset();
    tMissThenHit();
    tFill();
    tRecency();
    tStoreNoReorder();
    tChannelFetch();
    tStoreThrough();
    tStoreNoAlloc();
    tHeld();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule